// File: doc/BRIEF.md
# Descriptor-Chained DMA Controller

This block is one DMA channel that copies 32-bit words between two address spaces, the host side and the local side. Software sets it up through a small word-addressed register port. It then drives a request/acknowledge master port toward each space on its own. While it runs it is the only master on both ports.

In block mode the channel takes its host address, local address, byte count and direction from registers. In chained mode it reads a list of four-word descriptors from memory and processes them one after another. It stops after the descriptor that carries an end-of-chain flag. Descriptors can sit in either space. When they sit in local memory, the channel can write a zero byte count back into each one after finishing it. On completion a sticky done bit is set. The interrupt output can follow completion, and it can also follow every descriptor load.

Register map (word index on `reg_addr`):
- 0, control. bit0 starts the channel and reads back 0. bit1 selects chained mode. bit2 is the block-mode direction. bit3 enables the done interrupt. bit4 enables the descriptor-load interrupt. bit5 places descriptors on the local side (1) or the host side (0). bit6 enables byte-count write-back.
- 1, host address.
- 2, local address.
- 3, byte count.
- 4, descriptor pointer.
- 5, status. bit0 is done, bit1 is busy, bit2 is load-pending. Writing 1 to bit0 or bit2 clears that bit.

Registers 1 to 4 are working registers and advance as the transfer proceeds.

Top module: `dma_chain_ctrl`

## Requirements
- R1: In block mode with direction 0, each word is a host-side read at the host address followed by a local-side write of that same word at the local address. Both addresses advance by 4 per word, and the count register ends at 0.
- R2: When the last descriptor or block finishes, status bit0 (done) becomes 1 and busy drops. Done stays set until cleared. The `irq` output is 1 while done is set and control bit3 is set.
- R3: With direction 1, each word is a local-side read followed by a host-side write of that word.
- R4: A byte count of n moves ceil(n/4) words. A byte count of 0 completes the descriptor with no data access.
- R5: Writing 1 to status bit0 clears done and drops the done interrupt. Starting the channel also clears done and load-pending.
- R6: In chained mode the channel reads the descriptor words at pointer+0, +4, +8 and +12, in that order: host address, local address, byte count, next word. In the next word, bit1 is end-of-chain and bit3 is direction. The next descriptor address is the next word with bits 3:0 cleared.
- R7: Descriptor reads go to the local port when control bit5 is 1 and to the host port when it is 0.
- R8: After a descriptor's data is moved, a local-side write of 0 to pointer+8 happens only if chained mode, bit5 and bit6 are all set.
- R9: When control bit4 is set, each descriptor load sets status bit2 and raises `irq`. Writing 1 to status bit2 clears it without touching done.
- R10: While busy, writes to control and to registers 1 to 4 are ignored, including a start.
- R11: A request holds its address, write flag and data until acknowledged. The two ports never request at the same time. Nothing is requested while idle.
- R12: After reset the channel is idle, with done, irq and both requests at 0 and status reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| h_req | output | 1 | Host-side access request |
| h_we | output | 1 | Host-side write (1) or read (0) |
| h_addr | output | 32 | Host-side byte address |
| h_wdata | output | 32 | Host-side write data |
| h_rdata | input | 32 | Host-side read data, valid with h_ack |
| h_ack | input | 1 | Host-side acknowledge |
| l_req | output | 1 | Local-side access request |
| l_we | output | 1 | Local-side write (1) or read (0) |
| l_addr | output | 32 | Local-side byte address |
| l_wdata | output | 32 | Local-side write data |
| l_rdata | input | 32 | Local-side read data, valid with l_ack |
| l_ack | input | 1 | Local-side acknowledge |
| done | output | 1 | Sticky end-of-transfer status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases:
- A byte count that is not a multiple of four: a design that truncates drops the last word, and one that does not saturate wraps into a runaway copy.
- A zero-count descriptor in the middle of a chain: a design that checks the count too late issues a stray read.
- Next words with their low flag bits mixed with junk: a design that forgets to mask would fetch from an unaligned address.
- Write-back enabled with descriptors on the host side, and a start written mid-transfer: either one shows up as an extra or reordered access in the compared access stream.
- The load interrupt must be visible right after the first descriptor fetch, not only at the end.

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        h_req,
  output logic        h_we,
  output logic [31:0] h_addr,
  output logic [31:0] h_wdata,
  input  logic [31:0] h_rdata,
  input  logic        h_ack,
  output logic        l_req,
  output logic        l_we,
  output logic [31:0] l_addr,
  output logic [31:0] l_wdata,
  input  logic [31:0] l_rdata,
  input  logic        l_ack,
  output logic        done,
  output logic        irq
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EVAL, S_RD, S_WR, S_FIN, S_WB} state_t;

  state_t      st;
  logic        chain_q, dir_cfg, done_ie, load_ie, dsc_local, wb_en;
  logic [31:0] haddr, laddr, cnt, dptr, xfer_word;
  logic [27:0] nxt;
  logic        eoc, dir, done_q, load_pend;
  logic [1:0]  fidx;

  wire busy     = (st != S_IDLE);
  wire wr_stat  = reg_we && (reg_addr == 3'd5);
  wire go       = reg_we && (reg_addr == 3'd0) && !busy && reg_wdata[0];
  wire wb_on    = chain_q && dsc_local && wb_en;
  wire last_desc = !chain_q || eoc;

  wire [31:0] fetch_addr = dptr + {28'd0, fidx, 2'b00};
  wire        fetch_ack  = dsc_local ? l_ack : h_ack;
  wire [31:0] fetch_word = dsc_local ? l_rdata : h_rdata;
  wire        src_ack    = dir ? l_ack : h_ack;
  wire [31:0] src_word   = dir ? l_rdata : h_rdata;
  wire        dst_ack    = dir ? h_ack : l_ack;
  wire [31:0] cnt_next   = (cnt > 32'd4) ? cnt - 32'd4 : 32'd0;
  wire        desc_end   = (st == S_FIN && !wb_on) || (st == S_WB && l_ack);

  assign h_req = (st == S_FETCH && !dsc_local) || (st == S_RD && !dir) || (st == S_WR && dir);
  assign l_req = (st == S_FETCH && dsc_local) || (st == S_RD && dir) || (st == S_WR && !dir) ||
                 (st == S_WB);
  assign h_we  = (st == S_WR);
  assign l_we  = (st == S_WR) || (st == S_WB);
  assign h_addr  = (st == S_FETCH) ? fetch_addr : haddr;
  assign l_addr  = (st == S_FETCH) ? fetch_addr : (st == S_WB) ? dptr + 32'd8 : laddr;
  assign h_wdata = xfer_word;
  assign l_wdata = (st == S_WB) ? 32'd0 : xfer_word;

  assign done = done_q;
  assign irq  = (done_q && done_ie) || load_pend;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {25'd0, wb_en, dsc_local, load_ie, done_ie, dir_cfg, chain_q, 1'b0};
      3'd1:    reg_rdata = haddr;
      3'd2:    reg_rdata = laddr;
      3'd3:    reg_rdata = cnt;
      3'd4:    reg_rdata = dptr;
      3'd5:    reg_rdata = {29'd0, load_pend, busy, done_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {chain_q, dir_cfg, done_ie, load_ie, dsc_local, wb_en} <= '0;
      haddr <= '0; laddr <= '0; cnt <= '0; dptr <= '0; xfer_word <= '0;
      nxt <= '0; eoc <= 1'b0; dir <= 1'b0; done_q <= 1'b0; load_pend <= 1'b0; fidx <= '0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[0]) done_q <= 1'b0;
        if (reg_wdata[2]) load_pend <= 1'b0;
      end
      if (reg_we && !busy) begin
        case (reg_addr)
          3'd0: {wb_en, dsc_local, load_ie, done_ie, dir_cfg, chain_q} <= reg_wdata[6:1];
          3'd1: haddr <= reg_wdata;
          3'd2: laddr <= reg_wdata;
          3'd3: cnt   <= reg_wdata;
          3'd4: dptr  <= reg_wdata;
          default: ;
        endcase
      end
      if (go) begin
        done_q    <= 1'b0;
        load_pend <= 1'b0;
        dir       <= reg_wdata[2];
        fidx      <= '0;
        st        <= reg_wdata[1] ? S_FETCH : S_EVAL;
      end
      case (st)
        S_FETCH: if (fetch_ack) begin
          case (fidx)
            2'd0: haddr <= fetch_word;
            2'd1: laddr <= fetch_word;
            2'd2: cnt   <= fetch_word;
            default: begin
              nxt <= fetch_word[31:4];
              eoc <= fetch_word[1];
              dir <= fetch_word[3];
              if (load_ie) load_pend <= 1'b1;
            end
          endcase
          fidx <= fidx + 2'd1;
          if (fidx == 2'd3) st <= S_EVAL;
        end
        S_EVAL: st <= (cnt == 32'd0) ? S_FIN : S_RD;
        S_RD: if (src_ack) begin
          xfer_word <= src_word;
          st <= S_WR;
        end
        S_WR: if (dst_ack) begin
          haddr <= haddr + 32'd4;
          laddr <= laddr + 32'd4;
          cnt   <= cnt_next;
          st    <= (cnt_next == 32'd0) ? S_FIN : S_RD;
        end
        S_FIN: if (wb_on) st <= S_WB;
        default: ;
      endcase
      if (desc_end) begin
        if (last_desc) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          dptr <= {nxt, 4'b0000};
          fidx <= '0;
          st   <= S_FETCH;
        end
      end
    end
  end

  assert_single_master_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && l_req));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!h_req && !l_req));

  assert_host_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_ack) |=> (h_req && $stable(h_addr) && $stable(h_we) && $stable(h_wdata)));

  assert_local_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (l_req && !l_ack) |=> (l_req && $stable(l_addr) && $stable(l_we) && $stable(l_wdata)));

  assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy));

  assert_done_clear_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

  assert_ctrl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |=>
      $stable({wb_en, dsc_local, load_ie, done_ie, dir_cfg, chain_q}));

endmodule

// File: tb/test_dma_chain_ctrl.sv
module test_dma_chain_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic h_req, h_we, l_req, l_we, done, irq;
  logic [31:0] h_addr, h_wdata, l_addr, l_wdata;
  logic [31:0] h_rdata = '0, l_rdata = '0;
  logic h_ack = 1'b0, l_ack = 1'b0;

  always #5 clk = ~clk;

  dma_chain_ctrl i_dma_chain_ctrl (.*);

  typedef struct { bit port; bit we; logic [31:0] addr; logic [31:0] data; } acc_t;
  acc_t exp_q[$];
  logic [31:0] hmem [0:255];
  logic [31:0] lmem [0:255];
  int checks = 0, errors = 0, cyc = 0;
  int h_wait = 0, l_wait = 0;
  string cur_tag = "R12";
  bit watch_on = 0, watch_hit = 0, watch_port = 0;
  logic [31:0] watch_addr = '0;
  logic irq_at_load = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic service(input bit p);
    logic [31:0] a, d;
    bit w;
    acc_t e;
    a = p ? l_addr : h_addr;
    w = p ? l_we : h_we;
    d = p ? l_wdata : h_wdata;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL %s actual unexpected access port %0d we %0d addr %h expected none", cur_tag, p, w, a);
    end else begin
      e = exp_q.pop_front();
      if (e.port != p || e.we != w || e.addr !== a || (w && e.data !== d)) begin
        errors++;
        $display("FAIL %s actual p%0d w%0d %h %h expected p%0d w%0d %h %h",
                 cur_tag, p, w, a, d, e.port, e.we, e.addr, e.data);
      end
    end
    if (watch_on && !w && p == watch_port && a == watch_addr) watch_hit = 1;
    if (w) begin
      if (p) lmem[a[9:2]] = d; else hmem[a[9:2]] = d;
    end else begin
      if (p) l_rdata = lmem[a[9:2]]; else h_rdata = hmem[a[9:2]];
    end
  endtask

  always @(negedge clk) begin
    if (watch_hit) begin
      irq_at_load = irq;
      watch_hit = 0;
      watch_on = 0;
    end
    if (h_ack) h_ack = 1'b0;
    else if (h_req) begin
      if (h_wait == 0) begin service(0); h_ack = 1'b1; h_wait = int'($urandom_range(0, 2)); end
      else h_wait--;
    end
    if (l_ack) l_ack = 1'b0;
    else if (l_req) begin
      if (l_wait == 0) begin service(1); l_ack = 1'b1; l_wait = int'($urandom_range(0, 2)); end
      else l_wait--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic model_words(input bit dr, input logic [31:0] h, input logic [31:0] l, input logic [31:0] n);
    int words = int'((n + 3) / 4);
    for (int i = 0; i < words; i++) begin
      logic [31:0] hh = h + 4 * i, ll = l + 4 * i;
      if (!dr) begin
        exp_q.push_back('{0, 0, hh, 32'd0});
        exp_q.push_back('{1, 1, ll, hmem[hh[9:2]]});
      end else begin
        exp_q.push_back('{1, 0, ll, 32'd0});
        exp_q.push_back('{0, 1, hh, lmem[ll[9:2]]});
      end
    end
  endtask

  task automatic model_chain(input logic [31:0] ptr, input bit dsp, input bit wb);
    logic [31:0] p = ptr;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w [4];
      for (int j = 0; j < 4; j++) begin
        logic [31:0] a = p + 4 * j;
        w[j] = dsp ? lmem[a[9:2]] : hmem[a[9:2]];
        exp_q.push_back('{dsp, 0, a, 32'd0});
      end
      model_words(w[3][3], w[0], w[1], w[2]);
      if (wb && dsp) exp_q.push_back('{1, 1, p + 8, 32'd0});
      if (w[3][1]) break;
      p = w[3] & ~32'hF;
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check({tag, " done"}, {31'd0, done}, 32'd1);
    check({tag, " all accesses"}, exp_q.size(), 0);
  endtask

  task automatic run_block(input logic [31:0] h, input logic [31:0] l, input logic [31:0] n, input logic [31:0] ctl);
    model_words(ctl[2], h, l, n);
    wreg(3'd1, h); wreg(3'd2, l); wreg(3'd3, n);
    wreg(3'd0, ctl);
  endtask

  logic [31:0] rd;

  initial begin
    for (int i = 0; i < 256; i++) begin
      hmem[i] = 32'hA000_0000 + i;
      lmem[i] = 32'h5000_0000 + i * 3;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_tag = "R12";
    check("R12 done", {31'd0, done}, 0);
    check("R12 irq", {31'd0, irq}, 0);
    check("R12 req", {30'd0, h_req, l_req}, 0);
    rreg(3'd5, rd); check("R12 status", rd, 0);

    cur_tag = "R1";
    run_block(32'h000, 32'h100, 32'd16, 32'h9);
    wait_done("R1");
    rreg(3'd3, rd); check("R1 count end", rd, 0);
    rreg(3'd1, rd); check("R1 host addr end", rd, 32'h010);
    rreg(3'd2, rd); check("R1 local addr end", rd, 32'h110);
    check("R2 done irq", {31'd0, irq}, 1);
    rreg(3'd5, rd); check("R2 status done not busy", rd, 32'h1);

    wreg(3'd5, 32'h1);
    @(negedge clk);
    check("R5 done cleared", {31'd0, done}, 0);
    check("R5 irq dropped", {31'd0, irq}, 0);

    cur_tag = "R3/R4";
    run_block(32'h040, 32'h180, 32'd6, 32'h5);
    wait_done("R3");
    check("R2 no irq without enable", {31'd0, irq}, 0);
    rreg(3'd1, rd); check("R4 two words for six bytes", rd, 32'h048);
    wreg(3'd5, 32'h1);

    cur_tag = "R4 zero";
    run_block(32'h0E0, 32'h1E0, 32'd0, 32'h9);
    wait_done("R4");
    check("R4 zero count irq", {31'd0, irq}, 1);
    wreg(3'd5, 32'h1);

    cur_tag = "R10";
    run_block(32'h080, 32'h1C0, 32'd32, 32'h1);
    repeat (4) @(negedge clk);
    rreg(3'd5, rd); check("R10 busy seen", rd & 32'h2, 32'h2);
    wreg(3'd0, 32'h5);
    wreg(3'd1, 32'h3F0);
    wait_done("R10");
    rreg(3'd1, rd); check("R10 host addr write ignored", rd, 32'h0A0);
    rreg(3'd0, rd); check("R10 control write ignored", rd, 32'h0);
    wreg(3'd5, 32'h1);

    cur_tag = "R6/R7";
    hmem[8'hC0] = 32'h000; hmem[8'hC1] = 32'h200; hmem[8'hC2] = 32'd8;  hmem[8'hC3] = 32'h345;
    hmem[8'hD0] = 32'h020; hmem[8'hD1] = 32'h220; hmem[8'hD2] = 32'd0;  hmem[8'hD3] = 32'h388;
    hmem[8'hE0] = 32'h060; hmem[8'hE1] = 32'h240; hmem[8'hE2] = 32'd12; hmem[8'hE3] = 32'h00A;
    model_chain(32'h300, 0, 1);
    wreg(3'd4, 32'h300);
    wreg(3'd0, 32'h4B);
    wait_done("R6");
    check("R8 host descriptors keep count", hmem[8'hC2], 32'd8);
    check("R6 chain done irq", {31'd0, irq}, 1);
    rreg(3'd4, rd); check("R6 last descriptor pointer", rd, 32'h380);
    rreg(3'd5, rd); check("R9 no load pending when disabled", rd, 32'h1);
    wreg(3'd5, 32'h1);

    cur_tag = "R8/R9";
    lmem[8'hC0] = 32'h0C0; lmem[8'hC1] = 32'h260; lmem[8'hC2] = 32'd4; lmem[8'hC3] = 32'h310;
    lmem[8'hC4] = 32'h0D0; lmem[8'hC5] = 32'h270; lmem[8'hC6] = 32'd8; lmem[8'hC7] = 32'h00A;
    model_chain(32'h300, 1, 1);
    watch_port = 1; watch_addr = 32'h30C; watch_on = 1;
    wreg(3'd4, 32'h300);
    wreg(3'd0, 32'h73);
    wait_done("R8");
    check("R9 irq right after first load", {31'd0, irq_at_load}, 1);
    check("R8 first count written back", lmem[8'hC2], 0);
    check("R8 second count written back", lmem[8'hC6], 0);
    rreg(3'd5, rd); check("R9 load pending and done", rd, 32'h5);
    check("R9 irq from load", {31'd0, irq}, 1);
    wreg(3'd5, 32'h4);
    @(negedge clk);
    check("R9 irq cleared", {31'd0, irq}, 0);
    rreg(3'd5, rd); check("R9 done kept", rd, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule